// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block takes a DDR2 memory from a cold reset to a state where normal traffic can begin. It owns the memory command bus: clock enable, chip select, RAS, CAS, WE, bank address and address lines. It steps through the fixed DDR2 bring-up program and leaves the bus idle when it finishes. Every delay in the program is given in nanoseconds or in clock cycles. The block converts each one to a cycle count from a clock-period parameter while it is elaborated.

The program runs as follows. First comes a long idle period with the clock enable held low. After that the clock enable rises, and after a second settle time the block issues a precharge of all banks. It then writes the extended mode registers 2, 3 and 1, and issues a mode register write that resets the DLL, followed by the DLL lock wait. Next come a second precharge of all banks, two refreshes and the operating mode register write. It ends with the off-chip-driver calibration default and exit writes. One cycle of the program's last wait later, a done flag rises towards the main controller. The mode register value is built from burst length, CAS latency and write recovery parameters. Any reset starts the program again from the beginning.

Top module: `ddr2_init_seq`

## Requirements
- R1: While rst_ni is low, cke_o is 0, the command {cs_n,ras_n,cas_n,we_n} is NOP (0111), ba_o and addr_o are 0 and init_done_o is 0.
- R2: cke_o rises exactly PWR_CYC = ceil(T_INIT_NS/clock period) cycles after reset is released and stays high until the next reset. Only NOP is driven before it rises.
- R3: The first command, precharge-all (0010) with addr_o[10]=1 and every other address and bank bit 0, appears exactly ceil(T_CKE_NS/period) cycles after cke_o rises.
- R4: Command encodings are NOP=0111, PRE=0010, REF=0001 and MRS/EMRS=0000 on {cs_n,ras_n,cas_n,we_n}. Exactly eleven commands are issued, in this order: PRE, EMRS(ba=2), EMRS(ba=3), EMRS(ba=1), MRS(ba=0), PRE, REF, REF, MRS(ba=0), EMRS(ba=1), EMRS(ba=1). Refresh commands drive bank and address 0.
- R5: The gap to the next command, in cycles, is ceil(T_RP_NS/period) after each precharge, ceil(T_RFC_NS/period) after each refresh, and T_MRD_CK after each mode-register write. After the DLL-reset MRS the gap is max(DLL_LOCK_CK, T_MRD_CK). Every cycle between commands carries NOP.
- R6: The mode register value has burst-length code 010 (BL4) or 011 (BL8) on A2:A0, CAS latency 2..5 as binary on A6:A4, and write recovery 2..6 as binary (WR-1) on A11:A9. A3, A7 and A10 and above are 0. A8 is 1 on the first MRS (DLL reset) and 0 on the second.
- R7: The EMRS(2) and EMRS(3) writes drive address 0. The first EMRS(1) drives address 0, which enables the DLL with A0=0. The second EMRS(1) sets A9:A7=111 with all other bits 0, and the third clears them to all-zero.
- R8: init_done_o rises exactly T_MRD_CK cycles after the last EMRS(1) write. It then stays high with NOP on the command bus until reset.
- R9: A reset applied at any point in the program aborts it, and after release the whole program repeats from the long idle period with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset, restarts the program |
| cke_o | output | 1 | Memory clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row address strobe, active low |
| cas_n_o | output | 1 | Column address strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address lines, carrying mode register contents |
| init_done_o | output | 1 | High once the program has completed |

## Verification
All outputs are registered. Each event therefore lands on the clock edge at which the preceding wait expires, and its cycle can be stated exactly from the reset release. The cke_o rise is due PWR_CYC edges after release. Each command is due one gap after the previous event, and init_done_o is due T_MRD_CK edges after the final write. The bench computes this absolute schedule from the parameters and counts edges from the release of reset. It samples on falling edges and compares each command cycle in full. It also tallies every cycle between events for stray commands and for wrong clock enable or done levels. Resets are injected at random and at directed points in the program, in two parameter sets, so that restarts and both burst-length encodings are covered.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [3:0] {
    ST_PWR,
    ST_CKE,
    ST_PRE1,
    ST_EMR2,
    ST_EMR3,
    ST_EMR1_DLL,
    ST_MRS_DLLRST,
    ST_PRE2,
    ST_REF1,
    ST_REF2,
    ST_MRS_RUN,
    ST_EMR1_OCD,
    ST_EMR1_EXIT,
    ST_DONE
  } step_e;

  // ceil(ns / period), never below one cycle
  function automatic int ns2cyc(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [2:0] bl_code(input int bl);
    return (bl == 8) ? 3'b011 : 3'b010;
  endfunction

  function automatic logic [2:0] cl_code(input int cl);
    return 3'(cl);
  endfunction

  function automatic logic [2:0] wr_code(input int wr);
    return 3'(wr - 1);
  endfunction

  // A11:A9 wr, A8 dll reset (0 here), A7 test, A6:A4 cl, A3 burst type, A2:A0 bl
  function automatic logic [11:0] mr_base(input int bl, input int cl, input int wr);
    return {wr_code(wr), 1'b0, 1'b0, cl_code(cl), 1'b0, bl_code(bl)};
  endfunction

endpackage

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
  parameter int               CNT_W   = 16,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= RST_VAL;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R5: a loaded non-zero wait is never skipped
  a_r5_wait_not_skipped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_val_i != '0) |=> !zero_o);

  // R5: an expired timer stays expired until reloaded
  a_r5_zero_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/ddr2_init_step_rom.sv
module ddr2_init_step_rom
  import ddr2_init_pkg::*;
#(
  parameter int          ADDR_W  = 14,
  parameter int          BA_W    = 2,
  parameter int          CNT_W   = 16,
  parameter int          PWR_CYC = 1,
  parameter int          CKE_CYC = 1,
  parameter int          RP_CYC  = 1,
  parameter int          RFC_CYC = 1,
  parameter int          MRD_CYC = 1,
  parameter int          DLL_CYC = 1,
  parameter logic [11:0] MR_BASE = '0
) (
  input  step_e             step_i,
  output cmd_e              cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cke_o,
  output logic [CNT_W-1:0]  wait_o
);

  localparam logic [ADDR_W-1:0] A_PRE_ALL = ADDR_W'(1) << 10;
  localparam logic [ADDR_W-1:0] A_MR_DLL  = ADDR_W'(MR_BASE) | (ADDR_W'(1) << 8);
  localparam logic [ADDR_W-1:0] A_MR_RUN  = ADDR_W'(MR_BASE);
  localparam logic [ADDR_W-1:0] A_OCD_DEF = ADDR_W'(3'b111) << 7;

  always_comb begin
    cmd_o  = CMD_NOP;
    ba_o   = '0;
    addr_o = '0;
    cke_o  = 1'b1;
    wait_o = CNT_W'(1);
    unique case (step_i)
      ST_PWR: begin
        cke_o  = 1'b0;
        wait_o = CNT_W'(PWR_CYC);
      end
      ST_CKE: wait_o = CNT_W'(CKE_CYC);
      ST_PRE1, ST_PRE2: begin
        cmd_o  = CMD_PRE;
        addr_o = A_PRE_ALL;
        wait_o = CNT_W'(RP_CYC);
      end
      ST_EMR2: begin
        cmd_o  = CMD_MRS;
        ba_o   = BA_W'(2);
        wait_o = CNT_W'(MRD_CYC);
      end
      ST_EMR3: begin
        cmd_o  = CMD_MRS;
        ba_o   = BA_W'(3);
        wait_o = CNT_W'(MRD_CYC);
      end
      ST_EMR1_DLL, ST_EMR1_EXIT: begin
        cmd_o  = CMD_MRS;
        ba_o   = BA_W'(1);
        wait_o = CNT_W'(MRD_CYC);
      end
      ST_EMR1_OCD: begin
        cmd_o  = CMD_MRS;
        ba_o   = BA_W'(1);
        addr_o = A_OCD_DEF;
        wait_o = CNT_W'(MRD_CYC);
      end
      ST_MRS_DLLRST: begin
        cmd_o  = CMD_MRS;
        addr_o = A_MR_DLL;
        wait_o = CNT_W'(max2(DLL_CYC, MRD_CYC));
      end
      ST_MRS_RUN: begin
        cmd_o  = CMD_MRS;
        addr_o = A_MR_RUN;
        wait_o = CNT_W'(MRD_CYC);
      end
      ST_REF1, ST_REF2: begin
        cmd_o  = CMD_REF;
        wait_o = CNT_W'(RFC_CYC);
      end
      ST_DONE: wait_o = CNT_W'(1);
      default: wait_o = CNT_W'(1);
    endcase
  end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int CLK_PS      = 8000,
  parameter int T_INIT_NS   = 200000,
  parameter int T_CKE_NS    = 400,
  parameter int T_RP_NS     = 15,
  parameter int T_RFC_NS    = 128,
  parameter int T_MRD_CK    = 2,
  parameter int DLL_LOCK_CK = 200,
  parameter int BURST_LEN   = 4,
  parameter int CAS_LAT     = 3,
  parameter int WR_RECOV    = 3,
  parameter int ADDR_W      = 14,
  parameter int BA_W        = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o
);

  localparam int PWR_CYC  = ns2cyc(T_INIT_NS, CLK_PS);
  localparam int CKE_CYC  = ns2cyc(T_CKE_NS, CLK_PS);
  localparam int RP_CYC   = ns2cyc(T_RP_NS, CLK_PS);
  localparam int RFC_CYC  = ns2cyc(T_RFC_NS, CLK_PS);
  localparam int MRD_CYC  = max2(T_MRD_CK, 1);
  localparam int DLL_CYC  = max2(DLL_LOCK_CK, 1);
  localparam int MAX_WAIT = max2(max2(PWR_CYC, CKE_CYC),
                                 max2(max2(RP_CYC, RFC_CYC), max2(MRD_CYC, DLL_CYC)));
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam logic [11:0] MR_BASE = mr_base(BURST_LEN, CAS_LAT, WR_RECOV);

  step_e             step_q, step_nxt;
  logic              tmr_zero, advance;
  cmd_e              rom_cmd, cmd_q;
  logic [BA_W-1:0]   rom_ba, ba_q;
  logic [ADDR_W-1:0] rom_addr, addr_q;
  logic              rom_cke, cke_q, done_q;
  logic [CNT_W-1:0]  rom_wait;

  assign step_nxt = (step_q == ST_DONE) ? ST_DONE : step_e'(step_q + 4'd1);
  assign advance  = tmr_zero && (step_q != ST_DONE);

  ddr2_init_step_rom #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W),
    .CNT_W  (CNT_W),
    .PWR_CYC(PWR_CYC),
    .CKE_CYC(CKE_CYC),
    .RP_CYC (RP_CYC),
    .RFC_CYC(RFC_CYC),
    .MRD_CYC(MRD_CYC),
    .DLL_CYC(DLL_CYC),
    .MR_BASE(MR_BASE)
  ) u_rom (
    .step_i(step_nxt),
    .cmd_o (rom_cmd),
    .ba_o  (rom_ba),
    .addr_o(rom_addr),
    .cke_o (rom_cke),
    .wait_o(rom_wait)
  );

  ddr2_init_timer #(
    .CNT_W  (CNT_W),
    .RST_VAL(CNT_W'(PWR_CYC - 1))
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (advance),
    .load_val_i(rom_wait - CNT_W'(1)),
    .zero_o    (tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_PWR;
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      cke_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      if (advance) begin
        step_q <= step_nxt;
        cmd_q  <= rom_cmd;
        ba_q   <= rom_ba;
        addr_q <= rom_addr;
        cke_q  <= rom_cke;
        done_q <= (step_nxt == ST_DONE);
      end
    end
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;
  assign ba_o        = ba_q;
  assign addr_o      = addr_q;
  assign cke_o       = cke_q;
  assign init_done_o = done_q;

  // R1, R2: no command while the clock enable is low
  a_r2_nop_without_cke: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111));

  a_r2_cke_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);

  a_r3_pre_all_a10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0010) |-> addr_o[10]);

  a_r4_refresh_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0001) |-> (ba_o == '0 && addr_o == '0));

  a_r8_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  a_r8_quiet_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111 && cke_o));

endmodule

// File: tb/ddr2_init_seq_tb.sv
`timescale 1ns/1ps
module ddr2_init_seq_tb;

  localparam int AW = 14;
  localparam int NEV = 11;

  // parameter set 0 (defaults) and set 1 (short power-up, BL8)
  localparam int P0_INIT = 200000, P0_CKE = 400, P0_RP = 15, P0_RFC = 128, P0_MRD = 2;
  localparam int P0_DLL = 200, P0_BL = 4, P0_CL = 3, P0_WR = 3;
  localparam int P1_INIT = 2000, P1_CKE = 400, P1_RP = 20, P1_RFC = 75, P1_MRD = 3;
  localparam int P1_DLL = 200, P1_BL = 8, P1_CL = 5, P1_WR = 6;
  localparam int CLK_PS = 8000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n [2];
  logic          cke_s [2], done_s [2];
  logic [3:0]    cmd_s [2];
  logic [1:0]    ba_s  [2];
  logic [AW-1:0] addr_s[2];

  logic c0_cs, c0_ras, c0_cas, c0_we, c1_cs, c1_ras, c1_cas, c1_we;
  logic cke0, cke1, done0, done1;
  logic [1:0] ba0, ba1;
  logic [AW-1:0] a0, a1;

  ddr2_init_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n[0]), .cke_o(cke0), .cs_n_o(c0_cs), .ras_n_o(c0_ras),
    .cas_n_o(c0_cas), .we_n_o(c0_we), .ba_o(ba0), .addr_o(a0), .init_done_o(done0));

  ddr2_init_seq #(
    .CLK_PS(CLK_PS), .T_INIT_NS(P1_INIT), .T_CKE_NS(P1_CKE), .T_RP_NS(P1_RP),
    .T_RFC_NS(P1_RFC), .T_MRD_CK(P1_MRD), .DLL_LOCK_CK(P1_DLL), .BURST_LEN(P1_BL),
    .CAS_LAT(P1_CL), .WR_RECOV(P1_WR), .ADDR_W(AW), .BA_W(2)
  ) u_dut_alt (
    .clk_i(clk), .rst_ni(rst_n[1]), .cke_o(cke1), .cs_n_o(c1_cs), .ras_n_o(c1_ras),
    .cas_n_o(c1_cas), .we_n_o(c1_we), .ba_o(ba1), .addr_o(a1), .init_done_o(done1));

  assign cmd_s[0] = {c0_cs, c0_ras, c0_cas, c0_we};
  assign cmd_s[1] = {c1_cs, c1_ras, c1_cas, c1_we};
  assign cke_s[0] = cke0;  assign cke_s[1] = cke1;
  assign done_s[0] = done0; assign done_s[1] = done1;
  assign ba_s[0] = ba0;    assign ba_s[1] = ba1;
  assign addr_s[0] = a0;   assign addr_s[1] = a1;

  int n_chk = 0;
  int n_err = 0;

  int          t_cke [2];
  int          t_done[2];
  int          ev_t  [2][NEV];
  logic [19:0] ev_v  [2][NEV];
  string       ev_req[NEV];

  function automatic int to_cyc(int ns);
    int c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic logic [19:0] pack(logic [3:0] c, logic [1:0] b, logic [AW-1:0] a);
    return {c, b, a};
  endfunction

  task automatic build(int d, int pi, int pc, int prp, int prfc, int mrd, int dll,
                       int bl, int cl, int wr);
    logic [AW-1:0] mr;
    int gap [NEV];
    int rp = to_cyc(prp), rfc = to_cyc(prfc);
    int dg = (dll > mrd) ? dll : mrd;
    // R6: mode register fields
    mr = AW'(((bl == 8) ? 3 : 2) | (cl << 4) | ((wr - 1) << 9));
    ev_v[d][0]  = pack(4'b0010, 2'd0, AW'(1 << 10));
    ev_v[d][1]  = pack(4'b0000, 2'd2, '0);
    ev_v[d][2]  = pack(4'b0000, 2'd3, '0);
    ev_v[d][3]  = pack(4'b0000, 2'd1, '0);
    ev_v[d][4]  = pack(4'b0000, 2'd0, mr | AW'(1 << 8));
    ev_v[d][5]  = pack(4'b0010, 2'd0, AW'(1 << 10));
    ev_v[d][6]  = pack(4'b0001, 2'd0, '0);
    ev_v[d][7]  = pack(4'b0001, 2'd0, '0);
    ev_v[d][8]  = pack(4'b0000, 2'd0, mr);
    ev_v[d][9]  = pack(4'b0000, 2'd1, AW'(7 << 7));
    ev_v[d][10] = pack(4'b0000, 2'd1, '0);
    gap = '{rp, mrd, mrd, mrd, dg, rp, rfc, rfc, mrd, mrd, mrd};
    t_cke[d] = to_cyc(pi);
    ev_t[d][0] = t_cke[d] + to_cyc(pc);
    for (int i = 1; i < NEV; i++) ev_t[d][i] = ev_t[d][i-1] + gap[i-1];
    t_done[d] = ev_t[d][NEV-1] + gap[NEV-1];
  endtask

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // stop_at = 0: run to completion plus a random tail
  task automatic run(int d, int stop_at);
    int limit, cke_bad = 0, quiet_bad = 0, done_bad = 0, pre_bad = 0;
    rst_n[d] = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(cke_s[d] == 1'b0 && cmd_s[d] == 4'b0111 && done_s[d] == 1'b0 &&
            ba_s[d] == 2'd0 && addr_s[d] == '0, "R1", "reset outputs",
            {cke_s[d], done_s[d], pack(cmd_s[d], ba_s[d], addr_s[d])},
            {2'b00, pack(4'b0111, 2'd0, '0)});
    end
    rst_n[d] = 1'b1;
    limit = (stop_at > 0) ? stop_at : t_done[d] + int'($urandom_range(60, 20));
    for (int c = 1; c <= limit; c++) begin
      int idx = -1;
      logic [19:0] act;
      @(negedge clk);
      act = pack(cmd_s[d], ba_s[d], addr_s[d]);
      for (int i = 0; i < NEV; i++) if (ev_t[d][i] == c) idx = i;
      if (cke_s[d] !== (c >= t_cke[d])) cke_bad++;
      if (done_s[d] !== (c >= t_done[d])) done_bad++;
      if (idx >= 0)
        check(act == ev_v[d][idx], ev_req[idx], $sformatf("dut%0d command %0d at cycle %0d", d, idx, c),
              act, ev_v[d][idx]);
      else if (act != pack(4'b0111, 2'd0, '0)) begin
        if (c < ev_t[d][0]) pre_bad++;
        else quiet_bad++;
      end
    end
    check(cke_bad == 0, "R2", $sformatf("dut%0d cke cycles wrong", d), cke_bad, 0);
    check(pre_bad == 0, "R2", $sformatf("dut%0d commands before first precharge", d), pre_bad, 0);
    check(quiet_bad == 0, "R5", $sformatf("dut%0d non-NOP between commands", d), quiet_bad, 0);
    check(done_bad == 0, "R8", $sformatf("dut%0d init_done cycles wrong", d), done_bad, 0);
  endtask

  initial begin
    rst_n[0] = 1'b0;
    rst_n[1] = 1'b0;
    void'($urandom(32'h5eed_0d02));
    ev_req = '{"R3", "R7", "R7", "R7", "R6", "R4", "R4", "R4", "R6", "R7", "R7"};
    build(0, P0_INIT, P0_CKE, P0_RP, P0_RFC, P0_MRD, P0_DLL, P0_BL, P0_CL, P0_WR);
    build(1, P1_INIT, P1_CKE, P1_RP, P1_RFC, P1_MRD, P1_DLL, P1_BL, P1_CL, P1_WR);

    // alternate set: full, directed aborts (R9), random aborts, full again
    run(1, 0);
    run(1, t_cke[1]);              // R9: abort right at clock enable rise
    run(1, ev_t[1][4] + 7);        // R9: abort inside DLL lock wait
    run(1, t_done[1] - 1);         // R9: abort one cycle before done
    for (int k = 0; k < 4; k++) run(1, int'($urandom_range(t_done[1] - 1, 1)));
    run(1, 0);

    // default set: full, random abort, full
    run(0, 0);
    run(0, int'($urandom_range(t_done[0] - 1, t_cke[0] - 5)));
    run(0, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(190000 * 8);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule